// File: doc/BRIEF.md
# Key-Guarded Two-Stage Watchdog Timer

This block is a watchdog timer that software reaches over a small register bus with a 64-byte window. The timer counts down in two stages: a first stage that starts from one preload value, then a second stage that starts from another. When the second stage runs out, the block sets a timeout flag and drives its reset request and timeout pin outputs. A prescaler divides the system clock before it reaches the down counter. A configuration bit picks one of two divide ranges.

Writes to the two preloads and to the control byte (reload strobe and flag clear) take effect only if a two-byte key was written to the key byte just before them. A write-once lock bit freezes the configuration and the run controls until the next system reset. The timeout flag sits on its own power-on reset, so it survives the system reset that the watchdog itself requests. After a reboot, software can read it to tell that a watchdog expiry caused the reset.

A free-running mode is also available. In that mode an expiry of the second stage restarts the first stage and toggles the timeout pin, without requesting a reset.

Top module: `wdt_keyed_top`

## Requirements
- R1: After power-on and system reset, every readable register (preload 1 at 0x00, preload 2 at 0x04, control at 0x0D, configuration at 0x10, count at 0x14, run/lock at 0x18) reads 0, and all three outputs are low.
- R2: A write to preload 1, preload 2 or control (0x0D) takes effect only if the two writes just before it were 0x80 and then 0x86 to the key byte at 0x0C. Any other write between the two key bytes abandons the key, and an unkeyed guarded write leaves the register unchanged.
- R3: One key admits exactly one guarded write. A second guarded write without a fresh key is ignored.
- R4: Each count lasts D clock cycles, where D = 2^PRE_COARSE when configuration bit 2 is 0 and D = 2^PRE_FINE when it is 1. Register 0x14 returns the live count. Setting run bit 1 of 0x18 loads preload 1 and restarts the prescaler.
- R5: With preloads P and Q, counting from the load edge, stage 2 expires (P+1+Q+1)*D cycles later. When P is 0, it expires (Q+1)*D cycles later.
- R6: On expiry in watchdog mode, the reset request rises if configuration bit 4 is set, the cold select output also rises if bit 3 is set, and the timeout pin rises if bit 5 is set. The count then holds and the outputs stay asserted.
- R7: On expiry in watchdog mode, bit 1 of 0x0D becomes 1 and survives a system reset. Only power-on reset or a keyed write of 1 to that bit clears it. If an expiry and a clear land on the same edge, the flag ends up set.
- R8: A keyed write with bit 0 of 0x0D set restarts the count from the stage-1 start. A restart on the same edge as an expiry wins: no flag, no reset request.
- R9: Once bit 0 of 0x18 is set, writes to 0x10 and 0x18 are ignored until system reset.
- R10: Clearing run bit 1 of 0x18 stops the timer, and the count reads 0 from the next cycle on.
- R11: With bit 2 of 0x18 set (free-running), each stage-2 expiry restarts the count and toggles the timeout pin (when enabled). The reset request stays low and the flag stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low; clears the timeout flag |
| rst_n | input | 1 | System reset, active low; clears everything except the flag |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 6 | Register offset for reads and writes |
| bus_wdata | input | 32 | Write data, right-justified |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| wdt_rst_o | output | 1 | Reset request after expiry |
| wdt_cold_o | output | 1 | Reset request with cold type selected |
| wdt_pin_o | output | 1 | Timeout pin output |

## Verification
Two pairs of events can fall on the same clock edge. A keyed reload strobe can land on the very edge where stage 2 runs out, and a keyed flag clear can land on that same edge. The bench computes the expiry edge from the preloads and the divide ratio. It issues the key early, then idles for the exact number of cycles so that the guarded write is taken on that edge. For the reload case it checks that the reset request and flag stay low and that the count restarts at the stage-1 value. For the clear case it checks that the flag reads set afterwards.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;

  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;

  // register offsets inside the 64-byte window
  localparam logic [ADDR_W-1:0] OFF_PRE1 = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_PRE2 = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_KEY  = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 6'h0D;
  localparam logic [ADDR_W-1:0] OFF_CFG  = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_CNT  = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_RUN  = 6'h18;

  localparam logic [7:0] KEY_FIRST  = 8'h80;
  localparam logic [7:0] KEY_SECOND = 8'h86;

  // control byte
  localparam int CTRL_RELOAD = 0;
  localparam int CTRL_FLAG   = 1;
  // configuration
  localparam int CFG_FINE    = 2;
  localparam int CFG_PIN_EN  = 5;
  // run/lock
  localparam int RUN_LOCK    = 0;
  localparam int RUN_EN      = 1;
  localparam int RUN_FREE    = 2;

  typedef enum logic [1:0] {
    KEY_IDLE = 2'd0,
    KEY_HALF = 2'd1,
    KEY_OPEN = 2'd2
  } key_state_e;

  // packed so that field order equals configuration bits 5..2
  typedef struct packed {
    logic pin_en;
    logic rst_en;
    logic cold;
    logic fine;
  } cfg_t;

  function automatic logic is_guarded(input logic [ADDR_W-1:0] a);
    return (a == OFF_PRE1) || (a == OFF_PRE2) || (a == OFF_CTRL);
  endfunction

  // total cycles from load to stage-2 expiry
  function automatic int unsigned span_cycles(input int unsigned p,
                                              input int unsigned q,
                                              input int unsigned d);
    if (p == 0) return (q + 1) * d;
    return (p + 1 + q + 1) * d;
  endfunction

endpackage

// File: rtl/wdt_keyed_unlock.sv
module wdt_keyed_unlock
  import wdt_keyed_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wbyte,
  output logic              key_open
);

  key_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (wr_en) begin
      if (addr == OFF_KEY && wbyte == KEY_FIRST)
        st_d = KEY_HALF;
      else if (st_q == KEY_HALF && addr == OFF_KEY && wbyte == KEY_SECOND)
        st_d = KEY_OPEN;
      else
        st_d = KEY_IDLE;   // any other write consumes or breaks the key
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KEY_IDLE;
    else        st_q <= st_d;
  end

  assign key_open = (st_q == KEY_OPEN);

endmodule

// File: rtl/wdt_keyed_presc.sv
module wdt_keyed_presc #(
  parameter int COARSE = 15,
  parameter int FINE   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic fine,
  output logic tick
);

  localparam logic [COARSE-1:0] ONE    = COARSE'(1);
  localparam logic [COARSE-1:0] MASK_C = '1;
  localparam logic [COARSE-1:0] MASK_F = COARSE'((64'd1 << FINE) - 64'd1);

  logic [COARSE-1:0] div_q;
  logic [COARSE-1:0] mask;

  assign mask = fine ? MASK_F : MASK_C;
  assign tick = run && ((div_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               div_q <= '0;
    else if (!run || restart) div_q <= '0;
    else                      div_q <= div_q + ONE;
  end

endmodule

// File: rtl/wdt_keyed_count.sv
module wdt_keyed_count #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         load,
  input  logic         tick,
  input  logic         free_run,
  input  logic [W-1:0] pv1,
  input  logic [W-1:0] pv2,
  output logic [W-1:0] cnt,
  output logic         expired,
  output logic         load_ok,
  output logic         expire_evt,
  output logic         wrap_evt
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic         stage2_q;
  logic         expired_q;
  logic         stage_end;

  function automatic logic [W-1:0] start_count(input logic [W-1:0] a,
                                               input logic [W-1:0] b);
    return (a == '0) ? b : a;
  endfunction

  // once expired, only a fresh enable may restart
  assign load_ok   = load && (!expired_q || !run);
  assign stage_end = run && tick && !load_ok && !expired_q &&
                     stage2_q && (cnt_q == '0);
  assign expire_evt = stage_end && !free_run;
  assign wrap_evt   = stage_end && free_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      stage2_q  <= 1'b0;
      expired_q <= 1'b0;
    end else if (load_ok) begin
      cnt_q     <= start_count(pv1, pv2);
      stage2_q  <= (pv1 == '0);
      expired_q <= 1'b0;
    end else if (!run) begin
      cnt_q     <= '0;
      stage2_q  <= 1'b0;
      expired_q <= 1'b0;
    end else if (!expired_q && tick) begin
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - ONE;
      end else if (!stage2_q) begin
        cnt_q    <= pv2;
        stage2_q <= 1'b1;
      end else if (free_run) begin
        cnt_q    <= start_count(pv1, pv2);
        stage2_q <= (pv1 == '0);
      end else begin
        expired_q <= 1'b1;
      end
    end
  end

  assign cnt     = cnt_q;
  assign expired = expired_q;

endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
  import wdt_keyed_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int PRE_COARSE = 15,
  parameter int PRE_FINE   = 5
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdt_rst_o,
  output logic              wdt_cold_o,
  output logic              wdt_pin_o
);

  // named internal events
  logic             key_open;
  logic             guard_ok;
  logic             run_wr_ok;
  logic             en_set_evt;
  logic             strobe_ok;
  logic             flag_clr;
  logic             load_evt;
  logic             load_ok;
  logic             tick;
  logic             expire_evt;
  logic             wrap_evt;
  logic             expired;
  logic [CNT_W-1:0] cnt;

  // state
  logic [CNT_W-1:0] pv1_q, pv2_q;
  cfg_t             cfg_q;
  logic             lock_q, en_q, free_q;
  logic             flag_q;
  logic             tog_q;

  wdt_keyed_unlock u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_wr),
    .addr     (bus_addr),
    .wbyte    (bus_wdata[7:0]),
    .key_open (key_open)
  );

  assign guard_ok   = bus_wr && is_guarded(bus_addr) && key_open;
  assign run_wr_ok  = bus_wr && (bus_addr == OFF_RUN) && !lock_q;
  assign en_set_evt = run_wr_ok && bus_wdata[RUN_EN] && !en_q;
  assign strobe_ok  = guard_ok && (bus_addr == OFF_CTRL) && bus_wdata[CTRL_RELOAD];
  assign flag_clr   = guard_ok && (bus_addr == OFF_CTRL) && bus_wdata[CTRL_FLAG];
  assign load_evt   = (strobe_ok && en_q) || en_set_evt;

  wdt_keyed_presc #(
    .COARSE (PRE_COARSE),
    .FINE   (PRE_FINE)
  ) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (en_q),
    .restart (load_ok),
    .fine    (cfg_q.fine),
    .tick    (tick)
  );

  wdt_keyed_count #(
    .W (CNT_W)
  ) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (en_q),
    .load       (load_evt),
    .tick       (tick),
    .free_run   (free_q),
    .pv1        (pv1_q),
    .pv2        (pv2_q),
    .cnt        (cnt),
    .expired    (expired),
    .load_ok    (load_ok),
    .expire_evt (expire_evt),
    .wrap_evt   (wrap_evt)
  );

  // preloads, key guarded
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv1_q <= '0;
      pv2_q <= '0;
    end else if (guard_ok) begin
      if (bus_addr == OFF_PRE1) pv1_q <= bus_wdata[CNT_W-1:0];
      if (bus_addr == OFF_PRE2) pv2_q <= bus_wdata[CNT_W-1:0];
    end
  end

  // configuration and run/lock, frozen by the lock bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      lock_q <= 1'b0;
      en_q   <= 1'b0;
      free_q <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == OFF_CFG && !lock_q)
        cfg_q <= bus_wdata[CFG_PIN_EN:CFG_FINE];
      if (run_wr_ok) begin
        lock_q <= bus_wdata[RUN_LOCK];
        en_q   <= bus_wdata[RUN_EN];
        free_q <= bus_wdata[RUN_FREE];
      end
    end
  end

  // timeout flag lives in the power-on domain; set beats clear
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          flag_q <= 1'b0;
    else if (expire_evt) flag_q <= 1'b1;
    else if (flag_clr)   flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tog_q <= 1'b0;
    else if (wrap_evt) tog_q <= ~tog_q;
  end

  assign wdt_rst_o  = expired && cfg_q.rst_en;
  assign wdt_cold_o = expired && cfg_q.rst_en && cfg_q.cold;
  assign wdt_pin_o  = cfg_q.pin_en && (free_q ? tog_q : expired);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_PRE1: bus_rdata = DATA_W'(pv1_q);
      OFF_PRE2: bus_rdata = DATA_W'(pv2_q);
      OFF_CTRL: bus_rdata[CTRL_FLAG] = flag_q;
      OFF_CFG:  bus_rdata[CFG_PIN_EN:CFG_FINE] = cfg_q;
      OFF_CNT:  bus_rdata = DATA_W'(cnt);
      OFF_RUN:  bus_rdata[RUN_FREE:RUN_LOCK] = {free_q, en_q, lock_q};
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/wdt_keyed_sva.sv
module wdt_keyed_sva #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             key_open,
  input logic             guard_ok,
  input logic             expire_evt,
  input logic             flag_q,
  input logic             lock_q,
  input logic [3:0]       cfg_q,
  input logic             en_q,
  input logic             load_evt,
  input logic             tick,
  input logic             expired,
  input logic [CNT_W-1:0] cnt
);

  // R3: a key admits one guarded write
  a_r3_key_single_use: assert property (@(posedge clk) disable iff (!rst_n)
    guard_ok |=> !key_open);

  // R7: expiry sets the flag
  a_r7_flag_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> flag_q);

  // R9: lock stays set until reset
  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  // R9: configuration frozen while locked
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(cfg_q));

  // R10: a stopped timer reads zero
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !load_evt) |=> (cnt == '0));

  // R4: one step down per prescaler tick
  a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en_q && !load_evt && !expired && cnt != '0) |=>
      (cnt == $past(cnt) - CNT_W'(1)));

  // R6: expiry holds while running
  a_r6_expiry_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && en_q) |=> (expired && $stable(cnt)));

endmodule

bind wdt_keyed_top wdt_keyed_sva #(.CNT_W(CNT_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .key_open   (key_open),
  .guard_ok   (guard_ok),
  .expire_evt (expire_evt),
  .flag_q     (flag_q),
  .lock_q     (lock_q),
  .cfg_q      (cfg_q),
  .en_q       (en_q),
  .load_evt   (load_evt),
  .tick       (tick),
  .expired    (expired),
  .cnt        (cnt)
);

// File: tb/wdt_keyed_top_test.sv
module wdt_keyed_top_test;

  localparam int COARSE = 4;
  localparam int FINE   = 2;
  localparam int DC     = 1 << COARSE;
  localparam int DF     = 1 << FINE;

  localparam logic [5:0] A_P1 = 6'h00, A_P2 = 6'h04, A_KEY = 6'h0C,
                         A_CTL = 6'h0D, A_CFG = 6'h10, A_CNT = 6'h14,
                         A_RUN = 6'h18;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_rst_o, wdt_cold_o, wdt_pin_o;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  wdt_keyed_top #(.CNT_W(32), .PRE_COARSE(COARSE), .PRE_FINE(FINE)) uut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_rst_o(wdt_rst_o), .wdt_cold_o(wdt_cold_o), .wdt_pin_o(wdt_pin_o)
  );

  function automatic int expect_span(int p, int q, int d);
    int stages;
    stages = (p == 0) ? (q + 1) : (p + q + 2);
    return stages * d;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_reg(input string req, input logic [5:0] a,
                         input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, $sformatf("reg %0h", a), bus_rdata, exp);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic unlock();
    wr(A_KEY, 32'h80);
    wr(A_KEY, 32'h86);
  endtask

  task automatic kwr(input logic [5:0] a, input logic [31:0] d);
    unlock();
    wr(a, d);
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic full_reset();
    @(negedge clk);
    por_n = 1'b0; rst_n = 1'b0;
    wait_n(2);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic sys_reset();
    rst_n = 1'b0;
    wait_n(2);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic setup(input int p, input int q, input logic [31:0] cfg);
    full_reset();
    wr(A_CFG, cfg);
    kwr(A_P1, 32'(p));
    kwr(A_P2, 32'(q));
  endtask

  initial begin
    int p, q, d, t;
    logic [31:0] cfg;
    p = $urandom(32'd2024);

    full_reset();
    // R1 reset state
    chk("R1", "rst_o", {31'b0, wdt_rst_o}, 0);
    chk("R1", "pin_o", {31'b0, wdt_pin_o}, 0);
    chk_reg("R1", A_P1, 0); chk_reg("R1", A_P2, 0);
    @(negedge clk);
    chk_reg("R1", A_CTL, 0); chk_reg("R1", A_CFG, 0);
    @(negedge clk);
    chk_reg("R1", A_CNT, 0); chk_reg("R1", A_RUN, 0);
    @(negedge clk);

    // R2 key gating
    wr(A_P1, 5);
    chk_reg("R2", A_P1, 0);
    kwr(A_P1, 5);
    chk_reg("R2", A_P1, 5);
    wr(A_KEY, 32'h80); wr(A_CFG, 0); wr(A_KEY, 32'h86); wr(A_P1, 9);
    chk_reg("R2", A_P1, 5);
    wr(A_KEY, 32'h80); wr(A_KEY, 32'h85); wr(A_P1, 9);
    chk_reg("R2", A_P1, 5);
    // R3 one write per key
    kwr(A_P2, 3); wr(A_P2, 7);
    chk_reg("R3", A_P2, 3);

    // R4/R5/R6 watchdog mode, coarse range
    setup(2, 1, 32'h38);
    wr(A_RUN, 32'h2);
    chk_reg("R4", A_CNT, 2);
    wait_n(DC);
    chk_reg("R4", A_CNT, 1);
    t = expect_span(2, 1, DC);
    wait_n(t - DC - 1);
    chk("R5", "rst before", {31'b0, wdt_rst_o}, 0);
    @(negedge clk);
    chk("R5", "rst at span", {31'b0, wdt_rst_o}, 1);
    chk("R6", "cold", {31'b0, wdt_cold_o}, 1);
    chk("R6", "pin", {31'b0, wdt_pin_o}, 1);
    chk_reg("R7", A_CTL, 2);
    wait_n(3 * DC);
    chk("R6", "rst held", {31'b0, wdt_rst_o}, 1);
    chk_reg("R6", A_CNT, 0);
    // R7 flag survives system reset, cleared by keyed write
    @(negedge clk);
    sys_reset();
    chk("R7", "rst after sysreset", {31'b0, wdt_rst_o}, 0);
    chk_reg("R7", A_CTL, 2);
    kwr(A_CTL, 32'h2);
    chk_reg("R7", A_CTL, 0);

    // R4 fine range
    setup(2, 0, 32'h04);
    wr(A_RUN, 32'h2);
    wait_n(DF);
    chk_reg("R4", A_CNT, 1);

    // R5 stage 1 skipped when preload 1 is zero
    setup(0, 2, 32'h14);
    wr(A_RUN, 32'h2);
    t = expect_span(0, 2, DF);
    wait_n(t - 1);
    chk("R5", "p0 before", {31'b0, wdt_rst_o}, 0);
    @(negedge clk);
    chk("R5", "p0 at span", {31'b0, wdt_rst_o}, 1);

    // R5 random preloads and ranges
    for (int i = 0; i < 6; i++) begin
      p = int'($urandom() % 4);
      q = int'($urandom() % 4);
      d = (($urandom() % 2) == 1) ? DF : DC;
      cfg = (d == DF) ? 32'h14 : 32'h10;
      setup(p, q, cfg);
      wr(A_RUN, 32'h2);
      t = expect_span(p, q, d);
      wait_n(t - 1);
      chk("R5", $sformatf("rnd %0d before", i), {31'b0, wdt_rst_o}, 0);
      @(negedge clk);
      chk("R5", $sformatf("rnd %0d at span", i), {31'b0, wdt_rst_o}, 1);
    end

    // R8 reload mid-run restarts
    setup(1, 1, 32'h14);
    wr(A_RUN, 32'h2);
    wait_n(9);
    kwr(A_CTL, 32'h1);
    chk_reg("R8", A_CNT, 1);
    t = expect_span(1, 1, DF);
    wait_n(t - 1);
    chk("R8", "after reload before", {31'b0, wdt_rst_o}, 0);
    @(negedge clk);
    chk("R8", "after reload at span", {31'b0, wdt_rst_o}, 1);

    // R8 reload on the expiry edge wins
    setup(1, 1, 32'h14);
    wr(A_RUN, 32'h2);
    unlock();
    wait_n(expect_span(1, 1, DF) - 3);
    wr(A_CTL, 32'h1);
    chk("R8", "same edge rst", {31'b0, wdt_rst_o}, 0);
    chk_reg("R8", A_CTL, 0);
    chk_reg("R8", A_CNT, 1);
    wait_n(expect_span(1, 1, DF) - 1);
    chk("R8", "restart before", {31'b0, wdt_rst_o}, 0);
    @(negedge clk);
    chk("R8", "restart at span", {31'b0, wdt_rst_o}, 1);

    // R7 flag clear on the expiry edge loses
    setup(1, 1, 32'h14);
    wr(A_RUN, 32'h2);
    unlock();
    wait_n(expect_span(1, 1, DF) - 3);
    wr(A_CTL, 32'h2);
    chk("R7", "same edge rst", {31'b0, wdt_rst_o}, 1);
    chk_reg("R7", A_CTL, 2);
    // R7 power-on reset clears the flag
    @(negedge clk);
    full_reset();
    chk_reg("R7", A_CTL, 0);

    // R10 disable stops and clears
    setup(3, 3, 32'h10);
    wr(A_RUN, 32'h2);
    wait_n(20);
    chk_reg("R10", A_CNT, 2);
    @(negedge clk);
    wr(A_RUN, 32'h0);
    @(negedge clk);
    chk_reg("R10", A_CNT, 0);
    wait_n(5 * DC);
    chk_reg("R10", A_CNT, 0);
    chk("R10", "rst idle", {31'b0, wdt_rst_o}, 0);

    // R9 lock
    setup(3, 3, 32'h10);
    wr(A_RUN, 32'h3);
    chk_reg("R9", A_RUN, 3);
    wr(A_CFG, 32'h0);
    chk_reg("R9", A_CFG, 32'h10);
    wr(A_RUN, 32'h0);
    chk_reg("R9", A_RUN, 3);
    @(negedge clk);
    sys_reset();
    chk_reg("R9", A_RUN, 0);

    // R11 free-running toggles the pin
    setup(0, 1, 32'h34);
    wr(A_RUN, 32'h6);
    t = expect_span(0, 1, DF);
    wait_n(t - 1);
    chk("R11", "pin before", {31'b0, wdt_pin_o}, 0);
    @(negedge clk);
    chk("R11", "pin first", {31'b0, wdt_pin_o}, 1);
    wait_n(t);
    chk("R11", "pin second", {31'b0, wdt_pin_o}, 0);
    chk("R11", "no rst", {31'b0, wdt_rst_o}, 0);
    chk_reg("R11", A_CTL, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule